// File: doc/BRIEF.md
# Memory ECC Response Controller

This block stands between a processor bus port and a memory array whose 64-bit words each carry 8 check bits of an extended Hamming code. One request is presented at a time. With it comes the word the memory returned for that address. The block decodes the check bits, corrects a single flipped bit and recognises two flipped bits. It then acts according to the access type. It answers the bus, issues a memory write with freshly generated check bits, or does neither. Memory timing, refresh and the scrub address walk are left to the surrounding logic.

A memory error never aborts a bus cycle. Errors are reported in two ways. The first is a level interrupt and a level machine-check output, each with its own enable. The second is a sticky error log that holds the first error seen until software clears it. Partial writes are done as read-modify-write, and their write-back is skipped when the old word cannot be corrected. Scrub cycles write corrected data back only when scrub write-back is enabled.

Top module: `ecc_resp_ctrl`

## Requirements
- R1: The 7 Hamming check bits cover 72 code positions. Data bit i sits at the i-th position, counting upward from 3, whose number is not a power of two. Hamming check bit j is the XOR of the data bits whose position has bit j set. Check bit 7 makes the even parity of all 72 stored bits. The syndrome is {parity failure, stored Hamming bits XOR recomputed Hamming bits}. A zero syndrome means no error. A set parity-failure bit with a Hamming part of 71 or less is a single-bit error. Any other nonzero syndrome is a double-bit error.
- R2: Access kinds are 0 single read, 1 burst read beat, 2 single write, 3 burst write beat and 4 scrub. Results appear one clock after the request. A read raises rsp_valid and returns the data with any single-bit error corrected. An error in a check bit leaves the data unchanged.
- R3: A read with a double-bit error still raises rsp_valid and returns the raw memory data.
- R4: A single write raises rsp_valid and writes back a merged word. Bytes whose req_be bit is set come from the write data. The other bytes come from the corrected memory word. The word is written with check bits freshly generated per R1.
- R5: A single write whose old word has a double-bit error raises rsp_valid but issues no memory write.
- R6: A burst write beat writes req_wdata with fresh check bits, raises rsp_valid, ignores the memory word, and never reports an error.
- R7: A scrub never raises rsp_valid. It writes the corrected word back only on a single-bit error with scrub_wb_en set. It writes nothing on a clean word or a double-bit error.
- R8: irq rises after any detected error while irq_en is set. It stays high until log_clr.
- R9: mck rises after a double-bit error while mck_en is set. It stays high until log_clr. A single-bit error never raises it.
- R10: The first detected error stores its class (log_dbl), kind, address and syndrome and sets log_valid. Later errors leave the log unchanged until log_clr. An error arriving in the same cycle as log_clr is captured.
- R11: A request with a kind code from 5 to 7 has no effect on any output.
- R12: After reset, rsp_valid, mem_we, irq, mck and log_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind code |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for single writes |
| mem_rdata | input | 64 | Stored data of the addressed word |
| mem_rchk | input | 8 | Stored check bits of the addressed word |
| irq_en | input | 1 | Interrupt enable |
| mck_en | input | 1 | Machine-check enable |
| scrub_wb_en | input | 1 | Scrub write-back enable |
| log_clr | input | 1 | Clears the log, irq and mck |
| rsp_valid | output | 1 | Bus cycle completes |
| rsp_rdata | output | 64 | Read data returned to the requester |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | 64 | Write data to memory |
| mem_wchk | output | 8 | Check bits to memory |
| irq | output | 1 | Error interrupt level |
| mck | output | 1 | Machine-check level |
| log_valid | output | 1 | Log holds an error |
| log_dbl | output | 1 | Logged error was double-bit |
| log_kind | output | 3 | Logged access kind |
| log_addr | output | AW | Logged address |
| log_syn | output | 8 | Logged syndrome |

## Verification
The assertions assume that rst_n is held low long enough to clear the registers. They also assume that the memory word supplied with each request is the one stored at req_addr. The bench builds every supplied word by encoding clean data and then flipping zero, one or two distinct code bits. This keeps the decoder's class a known function of the flip count, since errors of three or more bits alias by design. Kind codes, enables and log_clr are drawn at random, including the reserved kind codes. Stimulus changes only on falling clock edges.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DW     = 64;
    localparam int HW     = 7;
    localparam int CW     = HW + 1;
    localparam int BW     = DW / 8;
    localparam int CODE_N = DW + CW;

    typedef enum logic [2:0] {
        ACC_RD_ONE  = 3'd0,
        ACC_RD_BEAT = 3'd1,
        ACC_WR_ONE  = 3'd2,
        ACC_WR_BEAT = 3'd3,
        ACC_SCRUB   = 3'd4
    } acc_e;

    // Hamming part over data, positions 1..CODE_N-1 with powers of two reserved
    function automatic logic [HW-1:0] ecc_hamming(input logic [DW-1:0] d);
        logic [HW-1:0] h;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p < CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int j = 0; j < HW; j++) begin
                    if (p[j]) h[j] = h[j] ^ d[k];
                end
                k++;
            end
        end
        return h;
    endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_pkg::*;
(
    input  logic [DW-1:0] enc_data,
    output logic [CW-1:0] enc_chk
);
    logic [HW-1:0] ham;

    always_comb begin
        ham     = ecc_hamming(enc_data);
        enc_chk = {^{enc_data, ham}, ham};
    end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
(
    input  logic [DW-1:0] dec_data,
    input  logic [CW-1:0] dec_chk,
    output logic [DW-1:0] fix_data,
    output logic [CW-1:0] syn,
    output logic          is_sgl,
    output logic          is_dbl
);
    logic [HW-1:0] ham;
    logic [HW-1:0] s;
    logic          pfail;
    int            k;

    always_comb begin
        ham    = ecc_hamming(dec_data);
        s      = ham ^ dec_chk[HW-1:0];
        pfail  = ^{dec_data, dec_chk};
        syn    = {pfail, s};
        is_sgl = pfail && (int'(s) < CODE_N);
        is_dbl = (!pfail && (s != '0)) || (pfail && (int'(s) >= CODE_N));
        fix_data = dec_data;
        k = 0;
        for (int p = 1; p < CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (is_sgl && (p == int'(s))) fix_data[k] = ~dec_data[k];
                k++;
            end
        end
    end
endmodule

// File: rtl/ecc_resp_ctrl.sv
module ecc_resp_ctrl
    import ecc_pkg::*;
#(
    parameter int AW = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [BW-1:0]     req_be,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [CW-1:0]     mem_rchk,
    input  logic              irq_en,
    input  logic              mck_en,
    input  logic              scrub_wb_en,
    input  logic              log_clr,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DW-1:0]     mem_wdata,
    output logic [CW-1:0]     mem_wchk,
    output logic              irq,
    output logic              mck,
    output logic              log_valid,
    output logic              log_dbl,
    output logic [2:0]        log_kind,
    output logic [AW-1:0]     log_addr,
    output logic [CW-1:0]     log_syn
);
    typedef struct packed {
        logic          rsp_valid;
        logic [DW-1:0] rsp_rdata;
        logic          we;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic [CW-1:0] wchk;
        logic          irq;
        logic          mck;
        logic          lv;
        logic          ldbl;
        logic [2:0]    lkind;
        logic [AW-1:0] laddr;
        logic [CW-1:0] lsyn;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] dec_fix;
    logic [CW-1:0] dec_syn;
    logic          dec_sgl, dec_dbl;
    logic [DW-1:0] merged;
    logic [DW-1:0] wsrc;
    logic [CW-1:0] wsrc_chk;
    acc_e          acc;
    logic          checked, err_hit, dbl_hit;

    ecc_dec u_dec (
        .dec_data (mem_rdata),
        .dec_chk  (mem_rchk),
        .fix_data (dec_fix),
        .syn      (dec_syn),
        .is_sgl   (dec_sgl),
        .is_dbl   (dec_dbl)
    );

    for (genvar b = 0; b < BW; b++) begin : g_merge
        assign merged[b*8 +: 8] = req_be[b] ? req_wdata[b*8 +: 8] : dec_fix[b*8 +: 8];
    end

    ecc_enc u_enc (
        .enc_data (wsrc),
        .enc_chk  (wsrc_chk)
    );

    always_comb begin
        acc = acc_e'(req_kind);
        unique case (acc)
            ACC_WR_ONE:  wsrc = merged;
            ACC_WR_BEAT: wsrc = req_wdata;
            default:     wsrc = dec_fix;
        endcase
        checked = req_valid && (acc == ACC_RD_ONE || acc == ACC_RD_BEAT ||
                                acc == ACC_WR_ONE || acc == ACC_SCRUB);
        err_hit = checked && (dec_sgl || dec_dbl);
        dbl_hit = checked && dec_dbl;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_rdata = '0;
        st_d.we        = 1'b0;
        if (req_valid) begin
            st_d.waddr = req_addr;
            st_d.wdata = wsrc;
            st_d.wchk  = wsrc_chk;
            case (acc)
                ACC_RD_ONE, ACC_RD_BEAT: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_rdata = dec_dbl ? mem_rdata : dec_fix;
                end
                ACC_WR_ONE: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.we        = !dec_dbl;
                end
                ACC_WR_BEAT: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.we        = 1'b1;
                end
                ACC_SCRUB: st_d.we = dec_sgl && scrub_wb_en;
                default: ;
            endcase
        end
        if (!st_q.lv || log_clr) begin
            st_d.lv = err_hit;
            if (err_hit) begin
                st_d.ldbl  = dec_dbl;
                st_d.lkind = req_kind;
                st_d.laddr = req_addr;
                st_d.lsyn  = dec_syn;
            end
        end
        st_d.irq = (st_q.irq && !log_clr) || (err_hit && irq_en);
        st_d.mck = (st_q.mck && !log_clr) || (dbl_hit && mck_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;
    assign mem_we    = st_q.we;
    assign mem_waddr = st_q.waddr;
    assign mem_wdata = st_q.wdata;
    assign mem_wchk  = st_q.wchk;
    assign irq       = st_q.irq;
    assign mck       = st_q.mck;
    assign log_valid = st_q.lv;
    assign log_dbl   = st_q.ldbl;
    assign log_kind  = st_q.lkind;
    assign log_addr  = st_q.laddr;
    assign log_syn   = st_q.lsyn;

    // Independent decode of the outgoing write word
    logic [DW-1:0] wb_fix;
    logic [CW-1:0] wb_syn;
    logic          wb_sgl, wb_dbl;

    ecc_dec u_wb_dec (
        .dec_data (mem_wdata),
        .dec_chk  (mem_wchk),
        .fix_data (wb_fix),
        .syn      (wb_syn),
        .is_sgl   (wb_sgl),
        .is_dbl   (wb_dbl)
    );

    assert_fresh_chk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wb_syn == '0 && !wb_sgl && !wb_dbl && wb_fix == mem_wdata));

    assert_wr_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd2 && dec_dbl) |=> (rsp_valid && !mem_we));

    assert_burst_nolog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3 && !log_valid) |=> !log_valid);

    assert_scrub_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4) |=> !rsp_valid);

    assert_mck_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mck) |-> $past(req_valid && dec_dbl && mck_en));

    assert_log_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !log_clr) |=> (log_valid && $stable(log_addr) && $stable(log_syn)));

    assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > 3'd4) |=> (!rsp_valid && !mem_we));
endmodule

// File: tb/ecc_resp_ctrl_test.sv
module ecc_resp_ctrl_test;
    localparam int AW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_be = '0;
    logic [63:0]   mem_rdata = '0;
    logic [7:0]    mem_rchk = '0;
    logic          irq_en = 1'b0, mck_en = 1'b0, scrub_wb_en = 1'b0, log_clr = 1'b0;
    logic          rsp_valid, mem_we, irq, mck, log_valid, log_dbl;
    logic [63:0]   rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_waddr, log_addr;
    logic [7:0]    mem_wchk, log_syn;
    logic [2:0]    log_kind;

    int vectors = 0;
    int fails = 0;

    // bench model of the log and level outputs
    logic          m_lv = 0, m_dbl = 0, m_irq = 0, m_mck = 0;
    logic [2:0]    m_kind = 0;
    logic [AW-1:0] m_addr = 0;
    logic [7:0]    m_syn = 0;

    always #5 clk = ~clk;

    ecc_resp_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .mem_rdata(mem_rdata), .mem_rchk(mem_rchk), .irq_en(irq_en),
        .mck_en(mck_en), .scrub_wb_en(scrub_wb_en), .log_clr(log_clr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
        .irq(irq), .mck(mck), .log_valid(log_valid), .log_dbl(log_dbl),
        .log_kind(log_kind), .log_addr(log_addr), .log_syn(log_syn)
    );

    function automatic int bpos(input int i);
        int c = 0;
        for (int p = 3; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (c == i) return p;
                c++;
            end
        end
        return 0;
    endfunction

    function automatic logic [6:0] bham(input logic [63:0] d);
        logic [6:0] h = '0;
        for (int i = 0; i < 64; i++) if (d[i]) h = h ^ 7'(bpos(i));
        return h;
    endfunction

    function automatic logic [7:0] bchk(input logic [63:0] d);
        logic [6:0] h = bham(d);
        return {(^d) ^ (^h), h};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one request at a negedge; compare at the following negedge
    task automatic step(input logic [2:0] kind, input logic [AW-1:0] addr,
                        input logic [63:0] wd, input logic [7:0] be,
                        input logic [63:0] dtrue, input int nflip, input int fa, input int fb);
        logic [71:0] cw;
        logic [63:0] exp_rd, exp_wd;
        logic        chk_k, sgl, dbl, err, exp_rv, exp_we;
        logic [7:0]  syn;
        cw = {bchk(dtrue), dtrue};
        if (nflip >= 1) cw[fa] = ~cw[fa];
        if (nflip >= 2) cw[fb] = ~cw[fb];
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        req_be = be; mem_rdata = cw[63:0]; mem_rchk = cw[71:64];
        chk_k = (kind <= 3'd2 && kind != 3'd3) || kind == 3'd4;
        sgl = chk_k && nflip == 1;
        dbl = chk_k && nflip == 2;
        err = sgl || dbl;
        syn = {^cw, cw[70:64] ^ bham(cw[63:0])};
        exp_rv = kind <= 3'd3;
        exp_rd = dbl ? cw[63:0] : dtrue;
        exp_we = 1'b0;
        exp_wd = dtrue;
        case (kind)
            3'd2: begin
                exp_we = !dbl;
                for (int b = 0; b < 8; b++) if (be[b]) exp_wd[b*8 +: 8] = wd[b*8 +: 8];
            end
            3'd3: begin exp_we = 1'b1; exp_wd = wd; end
            3'd4: exp_we = sgl && scrub_wb_en;
            default: ;
        endcase
        if (!m_lv || log_clr) begin
            m_lv = err;
            if (err) begin m_dbl = dbl; m_kind = kind; m_addr = addr; m_syn = syn; end
        end
        m_irq = (m_irq && !log_clr) || (err && irq_en);
        m_mck = (m_mck && !log_clr) || (dbl && mck_en);
        @(negedge clk);
        check(rsp_valid == exp_rv, (kind == 3'd4) ? "R7 scrub rsp_valid" :
              (kind > 3'd4) ? "R11 reserved rsp_valid" : "R2 rsp_valid", 72'(rsp_valid), 72'(exp_rv));
        if (exp_rv && kind <= 3'd1)
            check(rsp_rdata == exp_rd, dbl ? "R3 raw data" : "R2 corrected data", 72'(rsp_rdata), 72'(exp_rd));
        check(mem_we == exp_we, (kind == 3'd2) ? "R5 write strobe" : (kind == 3'd4) ? "R7 scrub write" :
              (kind == 3'd3) ? "R6 burst write" : "R11 no write", 72'(mem_we), 72'(exp_we));
        if (exp_we) begin
            check(mem_wdata == exp_wd, "R4 merged data", 72'(mem_wdata), 72'(exp_wd));
            check(mem_wchk == bchk(exp_wd), "R1 fresh check bits", 72'(mem_wchk), 72'(bchk(exp_wd)));
            check(mem_waddr == addr, "R4 write addr", 72'(mem_waddr), 72'(addr));
        end
        check(irq == m_irq, "R8 irq", 72'(irq), 72'(m_irq));
        check(mck == m_mck, "R9 mck", 72'(mck), 72'(m_mck));
        check(log_valid == m_lv, "R10 log_valid", 72'(log_valid), 72'(m_lv));
        if (m_lv) begin
            check(log_dbl == m_dbl, "R1 logged class", 72'(log_dbl), 72'(m_dbl));
            check(log_kind == m_kind, "R10 logged kind", 72'(log_kind), 72'(m_kind));
            check(log_addr == m_addr, "R10 logged addr", 72'(log_addr), 72'(m_addr));
            check(log_syn == m_syn, "R1 logged syndrome", 72'(log_syn), 72'(m_syn));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check(!rsp_valid && !mem_we && !irq && !mck && !log_valid, "R12 reset state",
              72'({rsp_valid, mem_we, irq, mck, log_valid}), 72'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !mem_we && !irq && !mck && !log_valid, "R12 idle after reset",
              72'({rsp_valid, mem_we, irq, mck, log_valid}), 72'(0));

        // directed corners
        irq_en = 1; mck_en = 1; scrub_wb_en = 0;
        d = 64'h0123_4567_89ab_cdef;
        step(3'd0, 28'h10, '0, '0, d, 0, 0, 0);          // R2 clean read
        step(3'd0, 28'h11, '0, '0, d, 1, 17, 0);         // R2 data bit flip
        step(3'd1, 28'h12, '0, '0, d, 1, 66, 0);         // R2 check bit flip, R10 sticky
        log_clr = 1;
        step(3'd1, 28'h13, '0, '0, d, 2, 5, 40);         // R3 + R10 capture on clear
        log_clr = 0;
        step(3'd2, 28'h14, ~d, 8'h0f, d, 2, 1, 2);       // R5 skip write
        log_clr = 1;
        step(3'd0, 28'h15, '0, '0, d, 0, 0, 0);
        log_clr = 0;
        step(3'd2, 28'h16, ~d, 8'hA5, d, 1, 63, 0);      // R4 merge with correction
        step(3'd4, 28'h17, '0, '0, d, 1, 3, 0);          // R7 write-back disabled
        scrub_wb_en = 1;
        step(3'd4, 28'h18, '0, '0, d, 1, 71, 0);         // R7 parity-bit error written back
        step(3'd4, 28'h19, '0, '0, d, 2, 8, 9);          // R7 double, no write
        log_clr = 1; irq_en = 0; mck_en = 0;
        step(3'd3, 28'h1a, 64'hdead_beef_0000_ffff, '0, d, 2, 0, 1); // R6 ignores memory word
        log_clr = 0;
        step(3'd6, 28'h1b, d, 8'hff, d, 2, 4, 9);        // R11 reserved kind
        step(3'd0, 28'h1c, '0, '0, d, 2, 10, 20);        // R8/R9 disabled, log still set

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k, nf, a, b;
            logic [63:0] dd;
            dd = {$urandom(), $urandom()};
            k = (($urandom() % 10) == 0) ? 5 + int'($urandom() % 3) : int'($urandom() % 5);
            nf = int'($urandom() % 3);
            a = int'($urandom() % 72);
            b = (a + 1 + int'($urandom() % 71)) % 72;
            irq_en = $urandom() % 4 != 0;
            mck_en = $urandom() % 4 != 0;
            scrub_wb_en = $urandom() % 2 != 0;
            log_clr = ($urandom() % 6) == 0;
            step(3'(k), AW'($urandom()), {$urandom(), $urandom()}, 8'($urandom()), dd, nf, a, b);
        end
        req_valid = 0; log_clr = 0;
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule